// File: doc/BRIEF.md
# Streaming Filter Job Dispatcher

This block sits at both ends of a free-running matrix-filter engine. Commands arrive as 32-bit words on a valid/ready input stream. The block collects each command, checks its matrix dimensions, and hands one item per command to a downstream job queue. A well-formed filter job carries its addresses and sizes with it. A job with an illegal size becomes a marker that carries no data. An end command becomes a drain marker.

The stage that processes the items, a stub in this project, returns one done strobe per item, in the order the items were handed over. The block uses those strobes to send one two-word response per job, in job order, on a 32-bit output stream. The block does not wait for a job to finish before taking the next command, so jobs overlap up to a parameterised tracking depth.

Errors are reported in the response and never stall later jobs. The drain marker must travel through the whole pipeline and come back before the block raises its sticky finished flag.

Top module: `fir_job_dispatch`

## Requirements
- R1: A command is seven 32-bit beats, one per input handshake, in this order: opcode, transaction id, input base, taps base, output base, row count, column count.
- R2: Opcode 0 with legal dimensions is dispatched as item kind 0. The transaction id, the three bases, the row count and the column count appear unchanged on the job outputs.
- R3: Dimensions are legal only when NUM_TAPS <= columns <= 1024 and 1 <= rows <= 64. Otherwise opcode 0 is dispatched as item kind 1, with the transaction id kept and all base and size outputs zero.
- R4: Any opcode other than 0 or 1 is handled as a bad-size job: item kind 1, and response status 1.
- R5: Opcode 1 is dispatched as item kind 2, with the transaction id kept and all base and size outputs zero. From its last beat onward, cmdReady stays low.
- R6: Each done strobe completes the oldest dispatched item that is not yet completed. A strobe arriving while no such item exists is ignored.
- R7: Every completed item of kind 0 or 1 produces two response words: first the transaction id, then the status (0 for kind 0, 1 for kind 1). Responses come strictly in dispatch order. The drain marker produces no response.
- R8: While respValid is high and respReady is low, respValid and respData hold. While jobValid is high and jobReady is low, the job outputs hold.
- R9: Commands keep being accepted while earlier items are outstanding, up to TRK_DEPTH items dispatched but not yet responded. Dispatch waits when that limit is reached.
- R10: finished rises only once the drain marker has completed and every earlier response has been sent. It then stays high until reset.
- R11: During reset, cmdReady is 1 and jobValid, respValid and finished are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command beat valid |
| cmdReady | output | 1 | Command beat accepted |
| cmdData | input | 32 | Command beat |
| jobValid | output | 1 | Dispatched item valid |
| jobReady | input | 1 | Downstream queue accepts item |
| jobKind | output | 2 | 0 job, 1 bad-size marker, 2 drain marker |
| jobTxId | output | 32 | Transaction id |
| jobInBase | output | 32 | Input matrix base (zero for markers) |
| jobTapBase | output | 32 | Taps base (zero for markers) |
| jobOutBase | output | 32 | Output matrix base (zero for markers) |
| jobRows | output | 32 | Row count (zero for markers) |
| jobCols | output | 32 | Column count (zero for markers) |
| doneStrobe | input | 1 | Oldest outstanding item completed |
| respValid | output | 1 | Response word valid |
| respReady | input | 1 | Response word accepted |
| respData | output | 32 | Transaction id, then status |
| finished | output | 1 | Drain complete, sticky |

## Verification
The bench builds the block with NUM_TAPS at 16, so the lower column bound sits at 15/16. It shrinks TRK_DEPTH to 2, so the tracking limit is reached within a few jobs. With random ready and done patterns, dispatch therefore stalls on a full tracker, and completions and responses pile up behind backpressure. The row and column limits are probed on both sides, together with an unknown opcode, a stray strobe before any job, and the drain path.

// File: rtl/fjd_pkg.sv
package fjd_pkg;
  localparam int CMD_BEATS = 7;
  localparam int BEAT_W = 3;

  // Beat positions inside a command; the order is the wire protocol.
  localparam int F_OP = 0;
  localparam int F_TX = 1;
  localparam int F_IN = 2;
  localparam int F_TAP = 3;
  localparam int F_OUT = 4;
  localparam int F_ROWS = 5;
  localparam int F_COLS = 6;

  localparam logic [31:0] OP_RUN = 32'd0;
  localparam logic [31:0] OP_END = 32'd1;

  typedef enum logic [1:0] {
    KIND_JOB = 2'd0,
    KIND_BAD = 2'd1,
    KIND_END = 2'd2
  } itemKind_t;

  typedef struct packed {
    logic beatTake;
    logic [BEAT_W-1:0] beatIdx;
    logic issue;
    logic cplMark;
    logic headPop;
    logic respPhase;
  } ctlStrobes_t;

  typedef struct packed {
    logic asmIsEnd;
    logic trkFull;
    logic hasUncompleted;
    logic headDone;
    itemKind_t headKind;
  } dpStatus_t;
endpackage

// File: rtl/fjd_ctrl.sv
module fjd_ctrl
  import fjd_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cmdValid,
  output logic cmdReady,
  output logic jobValid,
  input  logic jobReady,
  input  logic doneStrobe,
  output logic respValid,
  input  logic respReady,
  output logic finished,
  input  dpStatus_t st,
  output ctlStrobes_t stb
);
  logic [BEAT_W-1:0] beatCnt;
  logic haveCmd;
  logic stopped;
  logic jobValidR;
  logic respPhase;
  logic finishedR;

  logic take, lastBeat, issue, cpl, respFire, endPop;

  assign cmdReady = !haveCmd && !stopped;
  assign take = cmdValid && cmdReady;
  assign lastBeat = beatCnt == BEAT_W'(CMD_BEATS - 1);
  assign issue = haveCmd && (!jobValidR || jobReady) && !st.trkFull;
  assign cpl = doneStrobe && st.hasUncompleted;
  assign respValid = st.headDone && (st.headKind != KIND_END);
  assign respFire = respValid && respReady;
  assign endPop = st.headDone && (st.headKind == KIND_END);

  assign jobValid = jobValidR;
  assign finished = finishedR;

  always_comb begin
    stb = '0;
    stb.beatTake = take;
    stb.beatIdx = beatCnt;
    stb.issue = issue;
    stb.cplMark = cpl;
    stb.headPop = (respFire && respPhase) || endPop;
    stb.respPhase = respPhase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatCnt <= '0;
      haveCmd <= 1'b0;
      stopped <= 1'b0;
      jobValidR <= 1'b0;
      respPhase <= 1'b0;
      finishedR <= 1'b0;
    end else begin
      if (take) beatCnt <= lastBeat ? '0 : beatCnt + 1'b1;
      if (take && lastBeat) haveCmd <= 1'b1;
      else if (issue) haveCmd <= 1'b0;
      if (take && lastBeat && st.asmIsEnd) stopped <= 1'b1;
      if (issue) jobValidR <= 1'b1;
      else if (jobReady) jobValidR <= 1'b0;
      if (respFire) respPhase <= !respPhase;
      if (endPop) finishedR <= 1'b1;
    end
  end

  // R10
  finished_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    finished |=> finished);

  // R5
  stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    finished |-> !cmdReady);

  // R9
  no_issue_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haveCmd && st.trkFull) |=> haveCmd);
endmodule

// File: rtl/fjd_datapath.sv
module fjd_datapath
  import fjd_pkg::*;
#(
  parameter int NUM_TAPS = 16,
  parameter int MAX_COLS = 1024,
  parameter int MAX_ROWS = 64,
  parameter int TRK_DEPTH = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic [31:0] cmdData,
  input  ctlStrobes_t stb,
  output dpStatus_t st,
  output logic [1:0] jobKind,
  output logic [31:0] jobTxId,
  output logic [31:0] jobInBase,
  output logic [31:0] jobTapBase,
  output logic [31:0] jobOutBase,
  output logic [31:0] jobRows,
  output logic [31:0] jobCols,
  output logic [31:0] respData
);
  localparam int PTR_W = (TRK_DEPTH > 1) ? $clog2(TRK_DEPTH) : 1;
  localparam int CNT_W = $clog2(TRK_DEPTH + 1);

  // Command assembly: one register per beat.
  logic [CMD_BEATS-1:0][31:0] asmBus;
  for (genvar b = 0; b < CMD_BEATS; b++) begin : g_beat
    logic [31:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) word <= '0;
      else if (stb.beatTake && stb.beatIdx == BEAT_W'(b)) word <= cmdData;
    end
    assign asmBus[b] = word;
  end

  logic [31:0] asmOp, asmRows, asmCols;
  logic rowsOk, colsOk;
  itemKind_t asmKind;
  assign asmOp = asmBus[F_OP];
  assign asmRows = asmBus[F_ROWS];
  assign asmCols = asmBus[F_COLS];
  assign rowsOk = (asmRows != 32'd0) && (asmRows <= 32'(MAX_ROWS));
  assign colsOk = (asmCols >= 32'(NUM_TAPS)) && (asmCols <= 32'(MAX_COLS));

  always_comb begin
    if (asmOp == OP_END) asmKind = KIND_END;
    else if (asmOp == OP_RUN && rowsOk && colsOk) asmKind = KIND_JOB;
    else asmKind = KIND_BAD;
  end

  // Dispatch register toward the job queue.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      jobKind <= '0;
      jobTxId <= '0;
      jobInBase <= '0;
      jobTapBase <= '0;
      jobOutBase <= '0;
      jobRows <= '0;
      jobCols <= '0;
    end else if (stb.issue) begin
      jobKind <= asmKind;
      jobTxId <= asmBus[F_TX];
      if (asmKind == KIND_JOB) begin
        jobInBase <= asmBus[F_IN];
        jobTapBase <= asmBus[F_TAP];
        jobOutBase <= asmBus[F_OUT];
        jobRows <= asmRows;
        jobCols <= asmCols;
      end else begin
        jobInBase <= '0;
        jobTapBase <= '0;
        jobOutBase <= '0;
        jobRows <= '0;
        jobCols <= '0;
      end
    end
  end

  // In-order tracker of dispatched items awaiting their response.
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] trkCnt, uncCnt;
  logic [TRK_DEPTH-1:0][31:0] trkTxArr;
  logic [TRK_DEPTH-1:0][1:0] trkKindArr;

  for (genvar e = 0; e < TRK_DEPTH; e++) begin : g_ent
    logic [31:0] tx;
    logic [1:0] kind;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tx <= '0;
        kind <= '0;
      end else if (stb.issue && wrPtr == PTR_W'(e)) begin
        tx <= asmBus[F_TX];
        kind <= asmKind;
      end
    end
    assign trkTxArr[e] = tx;
    assign trkKindArr[e] = kind;
  end

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(TRK_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      trkCnt <= '0;
      uncCnt <= '0;
    end else begin
      if (stb.issue) wrPtr <= nextPtr(wrPtr);
      if (stb.headPop) rdPtr <= nextPtr(rdPtr);
      trkCnt <= trkCnt + CNT_W'(stb.issue) - CNT_W'(stb.headPop);
      uncCnt <= uncCnt + CNT_W'(stb.issue) - CNT_W'(stb.cplMark);
    end
  end

  itemKind_t headKind;
  assign headKind = itemKind_t'(trkKindArr[rdPtr]);

  always_comb begin
    st.asmIsEnd = (asmOp == OP_END);
    st.trkFull = (trkCnt == CNT_W'(TRK_DEPTH));
    st.hasUncompleted = (uncCnt != '0);
    st.headDone = (trkCnt > uncCnt);
    st.headKind = headKind;
  end

  assign respData = stb.respPhase ? {31'd0, headKind == KIND_BAD} : trkTxArr[rdPtr];

  // R9
  trk_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    trkCnt <= CNT_W'(TRK_DEPTH));

  // R6
  cpl_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    uncCnt <= trkCnt);

  // R6
  stray_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uncCnt == '0 && !stb.issue) |=> uncCnt == '0);
endmodule

// File: rtl/fir_job_dispatch.sv
module fir_job_dispatch
  import fjd_pkg::*;
#(
  parameter int NUM_TAPS = 16,
  parameter int MAX_COLS = 1024,
  parameter int MAX_ROWS = 64,
  parameter int TRK_DEPTH = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdValid,
  output logic cmdReady,
  input  logic [31:0] cmdData,
  output logic jobValid,
  input  logic jobReady,
  output logic [1:0] jobKind,
  output logic [31:0] jobTxId,
  output logic [31:0] jobInBase,
  output logic [31:0] jobTapBase,
  output logic [31:0] jobOutBase,
  output logic [31:0] jobRows,
  output logic [31:0] jobCols,
  input  logic doneStrobe,
  output logic respValid,
  input  logic respReady,
  output logic [31:0] respData,
  output logic finished
);
  ctlStrobes_t stb;
  dpStatus_t st;

  fjd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady),
    .jobValid(jobValid), .jobReady(jobReady),
    .doneStrobe(doneStrobe),
    .respValid(respValid), .respReady(respReady),
    .finished(finished),
    .st(st), .stb(stb)
  );

  fjd_datapath #(
    .NUM_TAPS(NUM_TAPS), .MAX_COLS(MAX_COLS),
    .MAX_ROWS(MAX_ROWS), .TRK_DEPTH(TRK_DEPTH)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .cmdData(cmdData), .stb(stb), .st(st),
    .jobKind(jobKind), .jobTxId(jobTxId),
    .jobInBase(jobInBase), .jobTapBase(jobTapBase), .jobOutBase(jobOutBase),
    .jobRows(jobRows), .jobCols(jobCols),
    .respData(respData)
  );

  // R8
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> (respValid && $stable(respData)));

  // R8
  job_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (jobValid && !jobReady) |=> (jobValid && $stable(jobTxId) && $stable(jobKind)));

  // R3
  marker_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (jobValid && jobKind != 2'd0) |-> (jobRows == '0 && jobCols == '0 && jobInBase == '0));
endmodule

// File: tb/fir_job_dispatch_tb_top.sv
module fir_job_dispatch_tb_top;
  localparam int TAPS = 16;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic cmdValid, cmdReady, jobValid, jobReady, doneStrobe;
  logic respValid, respReady, finished;
  logic [31:0] cmdData, respData;
  logic [1:0] jobKind;
  logic [31:0] jobTxId, jobInBase, jobTapBase, jobOutBase, jobRows, jobCols;

  fir_job_dispatch #(.NUM_TAPS(TAPS), .TRK_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData),
    .jobValid(jobValid), .jobReady(jobReady), .jobKind(jobKind),
    .jobTxId(jobTxId), .jobInBase(jobInBase), .jobTapBase(jobTapBase),
    .jobOutBase(jobOutBase), .jobRows(jobRows), .jobCols(jobCols),
    .doneStrobe(doneStrobe),
    .respValid(respValid), .respReady(respReady), .respData(respData),
    .finished(finished)
  );

  typedef struct {
    string req;
    logic [1:0] kind;
    logic [31:0] tx, inB, tapB, outB, rows, cols;
  } jobExp_t;

  jobExp_t jobQ[$];
  logic [31:0] respQ[$];
  int vectors = 0;
  int miscompares = 0;
  int outstanding = 0;
  int maxOutstanding = 0;
  bit stubAuto = 1'b0;
  bit runDone = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sendCmd(input string req, input logic [31:0] op, input logic [31:0] tx,
                         input logic [31:0] inB, input logic [31:0] tapB,
                         input logic [31:0] outB, input logic [31:0] rows,
                         input logic [31:0] cols);
    logic [31:0] w[7];
    jobExp_t e;
    bit legal;
    w = '{op, tx, inB, tapB, outB, rows, cols};
    legal = rows >= 1 && rows <= 64 && cols >= TAPS && cols <= 1024;
    e.req = req;
    e.tx = tx;
    e.inB = 0; e.tapB = 0; e.outB = 0; e.rows = 0; e.cols = 0;
    if (op == 0 && legal) begin
      e.kind = 2'd0;
      e.inB = inB; e.tapB = tapB; e.outB = outB; e.rows = rows; e.cols = cols;
    end else if (op == 1) e.kind = 2'd2;
    else e.kind = 2'd1;
    jobQ.push_back(e);
    if (e.kind != 2'd2) begin
      respQ.push_back(tx);
      respQ.push_back((e.kind == 2'd0) ? 32'd0 : 32'd1);
    end
    for (int b = 0; b < 7; b++) begin
      @(negedge clk);
      cmdValid = 1'b1;
      cmdData = w[b];
      while (!cmdReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  // Stub downstream stage: accepts items and returns done strobes in order.
  initial begin
    jobExp_t e;
    bit heldJob;
    logic [31:0] heldTx;
    heldJob = 1'b0;
    heldTx = '0;
    jobReady = 1'b0;
    doneStrobe = 1'b0;
    forever begin
      @(negedge clk);
      if (heldJob) begin
        chk(jobValid && jobTxId == heldTx, "R8", "held job tx", jobTxId, heldTx);
        heldJob = 1'b0;
      end
      if (stubAuto) begin
        doneStrobe = (outstanding > 0) && ($urandom_range(0, 3) == 0);
        if (doneStrobe) outstanding--;
      end
      jobReady = ($urandom_range(0, 3) != 0);
      if (rstN && jobValid) begin
        if (jobReady) begin
          if (jobQ.size() == 0) chk(1'b0, "R2", "unexpected job", jobTxId, 0);
          else begin
            e = jobQ.pop_front();
            chk(jobKind == e.kind && jobTxId == e.tx && jobInBase == e.inB &&
                jobTapBase == e.tapB && jobOutBase == e.outB &&
                jobRows == e.rows && jobCols == e.cols,
                e.req, "job item kind", jobKind, e.kind);
          end
          outstanding++;
          if (outstanding > maxOutstanding) maxOutstanding = outstanding;
        end else begin
          heldJob = 1'b1;
          heldTx = jobTxId;
        end
      end
    end
  end

  // Response monitor with random backpressure.
  initial begin
    logic [31:0] heldData, e;
    bit held;
    held = 1'b0;
    heldData = '0;
    respReady = 1'b0;
    forever begin
      @(negedge clk);
      if (held) begin
        chk(respValid && respData == heldData, "R8", "held response word", respData, heldData);
        held = 1'b0;
      end
      respReady = ($urandom_range(0, 2) != 0);
      if (rstN && respValid) begin
        if (respReady) begin
          if (respQ.size() == 0) chk(1'b0, "R7", "unexpected response word", respData, 0);
          else begin
            e = respQ.pop_front();
            chk(respData == e, "R7", "response word", respData, e);
          end
        end else begin
          held = 1'b1;
          heldData = respData;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!runDone) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    cmdValid = 1'b0;
    cmdData = '0;
    repeat (3) @(negedge clk);
    // R11
    chk(cmdReady == 1'b1, "R11", "cmdReady in reset", cmdReady, 1);
    chk(jobValid == 1'b0, "R11", "jobValid in reset", jobValid, 0);
    chk(respValid == 1'b0, "R11", "respValid in reset", respValid, 0);
    chk(finished == 1'b0, "R11", "finished in reset", finished, 0);
    rstN = 1'b1;

    // R6: a strobe with nothing outstanding must not complete the next job.
    @(negedge clk);
    doneStrobe = 1'b1;
    @(negedge clk);
    doneStrobe = 1'b0;
    sendCmd("R1", 0, 32'h0000_00A1, 32'h100, 32'h200, 32'h300, 4, 32);
    while (outstanding == 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(respValid == 1'b0, "R6", "response before completion", respValid, 0);
    doneStrobe = 1'b1;
    outstanding--;
    @(negedge clk);
    doneStrobe = 1'b0;
    while (respQ.size() != 0) @(negedge clk);
    chk(1'b1, "R6", "own strobe released response", 1, 1);

    stubAuto = 1'b1;
    sendCmd("R3", 0, 32'h10, 32'h1000, 32'h2000, 32'h3000, 1, TAPS);
    sendCmd("R3", 0, 32'h11, 32'h1000, 32'h2000, 32'h3000, 1, TAPS - 1);
    sendCmd("R3", 0, 32'h12, 32'h1100, 32'h2100, 32'h3100, 64, 1024);
    sendCmd("R3", 0, 32'h13, 32'h1100, 32'h2100, 32'h3100, 64, 1025);
    sendCmd("R3", 0, 32'h14, 32'h1200, 32'h2200, 32'h3200, 0, 64);
    sendCmd("R3", 0, 32'h15, 32'h1200, 32'h2200, 32'h3200, 65, 64);
    sendCmd("R4", 3, 32'h16, 32'h1300, 32'h2300, 32'h3300, 8, 64);
    for (int j = 0; j < 14; j++) begin
      sendCmd("R2", 0, 32'h100 + j, 32'h4000 + 64 * j, 32'h5000 + j,
              32'h6000 + 64 * j, 1 + (j % 5), TAPS + 7 * j);
    end
    sendCmd("R5", 1, 32'hE0D, 32'h7, 32'h7, 32'h7, 7, 7);

    while (!finished) @(negedge clk);
    // R10
    chk(respQ.size() == 0, "R10", "responses left at finish", respQ.size(), 0);
    chk(jobQ.size() == 0, "R5", "items left undispatched", jobQ.size(), 0);
    chk(cmdReady == 1'b0, "R5", "cmdReady after end", cmdReady, 0);
    // R9
    chk(maxOutstanding == DEPTH, "R9", "peak outstanding items", maxOutstanding, DEPTH);
    repeat (10) @(negedge clk);
    chk(finished == 1'b1, "R10", "finished sticky", finished, 1);
    chk(respValid == 1'b0, "R7", "no response for drain marker", respValid, 0);

    runDone = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule